// File: doc/BRIEF.md
# Double-Length Signed Integer Divider

This block divides a signed double-length dividend by a signed single-length divisor, one quotient bit per clock. The dividend arrives as two 36-bit words. The high word carries the sign and the upper magnitude bits. The low word supplies only its 35 lower bits, and its top bit is ignored. The divisor is one 36-bit two's-complement word. The results are a 36-bit two's-complement quotient and a 36-bit two's-complement remainder. Three flags report a divide that cannot produce a quotient that fits: overflow, divide-check and trap.

A request is a one-cycle `start_i` pulse with the operands valid in the same cycle. The block latches the operands. It then moves through its states:

- `S_IDLE` goes to `S_PREP` on start.
- In `S_PREP` the block forms operand magnitudes and runs the fit test. If the test fails, it goes from `S_PREP` back to `S_IDLE`. If the test passes, it goes from `S_PREP` to `S_ITER`.
- `S_ITER` performs 35 restoring shift-subtract steps and stays in `S_ITER` until the last one. After the last step it goes from `S_ITER` to `S_FIX`.
- `S_FIX` applies the result signs and goes from `S_FIX` back to `S_IDLE`.

`done_o` pulses for one cycle when the results or flags are updated.

The block is meant to sit beside an integer execution pipeline. Operand fetch and result write-back are handled elsewhere.

Top module: `wsd_divider`

## Requirements
- R1: The dividend is the 71-bit two's-complement value formed by the high word followed by bits 34..0 of the low word. Bit 35 of the low word has no effect on any output.
- R2: When the divide proceeds, the quotient magnitude is floor(|dividend| / |divisor|) and the remainder magnitude is |dividend| mod |divisor|. Both are returned as 36-bit two's complement.
- R3: When bits 70..35 of |dividend| are greater than or equal to |divisor|, overflow, divide-check and trap are all set. The quotient and remainder outputs keep their previous values, and `done_o` rises on the first rising edge after the one that sampled start.
- R4: A zero divisor always produces the divide-check result of R3.
- R5: The quotient is negative exactly when the dividend and divisor signs (bit 35 of each high word) differ and the magnitude is non-zero.
- R6: A non-zero remainder has the sign of the dividend.
- R7: A divide that proceeds raises `done_o` on the 37th rising edge after the one that sampled start, and clears all three flags.
- R8: A start pulse that arrives while a divide is in progress is ignored. It produces no extra done and does not alter the result in progress.
- R9: `done_o` is high for exactly one cycle per accepted request.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle |
| dvd_hi_i | input | 36 | Dividend high word (carries sign) |
| dvd_lo_i | input | 36 | Dividend low word, bit 35 ignored |
| dvsr_i | input | 36 | Divisor, two's complement |
| quotient_o | output | 36 | Signed quotient |
| remainder_o | output | 36 | Signed remainder |
| overflow_o | output | 1 | Overflow flag |
| div_check_o | output | 1 | Divide-check flag |
| trap_o | output | 1 | Trap flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a divide whose quotient sits at the edge of the fit test. In that case the high dividend magnitude is just below the divisor magnitude, so every one of the 35 steps matters and the quotient approaches its 35-bit limit. The stimulus reaches this with hand-picked operands: a divisor of 2^35-1 with a high word of 2^35-2, and the most negative dividend against several divisors. Random operands are drawn by arithmetically shifting random words, which keeps many high words below the divisor. A second start during a busy divide is injected mid-iteration. The check for it is that no unmatched done appears afterwards.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PREP = 2'd1,
        S_ITER = 2'd2,
        S_FIX  = 2'd3
    } wsd_state_e;

endpackage

// File: rtl/wsd_condition.sv
module wsd_condition #(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-1:0]   hi_i,
    input  logic [WORD_W-2:0]   lo_i,
    input  logic [WORD_W-1:0]   dvsr_i,
    output logic [WORD_W-1:0]   hi_mag_o,
    output logic [WORD_W-2:0]   lo_mag_o,
    output logic [WORD_W-1:0]   dvsr_mag_o,
    output logic                dvd_neg_o,
    output logic                quo_neg_o,
    output logic                check_o
);
    localparam int MAG_W  = WORD_W - 1;
    localparam int PAIR_W = WORD_W + MAG_W;

    logic [PAIR_W-1:0] pair;
    logic [PAIR_W-1:0] pair_mag;

    always_comb begin
        pair       = {hi_i, lo_i};
        pair_mag   = hi_i[WORD_W-1] ? (PAIR_W'(0) - pair) : pair;
        dvsr_mag_o = dvsr_i[WORD_W-1] ? (WORD_W'(0) - dvsr_i) : dvsr_i;
        hi_mag_o   = pair_mag[PAIR_W-1:MAG_W];
        lo_mag_o   = pair_mag[MAG_W-1:0];
        dvd_neg_o  = hi_i[WORD_W-1];
        quo_neg_o  = hi_i[WORD_W-1] ^ dvsr_i[WORD_W-1];
        check_o    = (pair_mag[PAIR_W-1:MAG_W] >= dvsr_mag_o);
    end

endmodule

// File: rtl/wsd_step.sv
module wsd_step #(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-1:0]   rem_i,
    input  logic [WORD_W-2:0]   lo_i,
    input  logic [WORD_W-1:0]   dvsr_i,
    output logic [WORD_W-1:0]   rem_o,
    output logic [WORD_W-2:0]   lo_o,
    output logic                bit_o
);
    localparam int MAG_W = WORD_W - 1;

    logic [WORD_W:0]   shifted;
    logic              fits;

    always_comb begin
        shifted = {rem_i, lo_i[MAG_W-1]};
        fits    = (shifted >= {1'b0, dvsr_i});
        rem_o   = fits ? (shifted[WORD_W-1:0] - dvsr_i) : shifted[WORD_W-1:0];
        lo_o    = {lo_i[MAG_W-2:0], 1'b0};
        bit_o   = fits;
    end

endmodule

// File: rtl/wsd_fixup.sv
module wsd_fixup #(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-2:0]   quo_mag_i,
    input  logic [WORD_W-1:0]   rem_mag_i,
    input  logic                quo_neg_i,
    input  logic                rem_neg_i,
    output logic [WORD_W-1:0]   quo_o,
    output logic [WORD_W-1:0]   rem_o
);
    logic [WORD_W-1:0] quo_ext;

    always_comb begin
        quo_ext = {1'b0, quo_mag_i};
        quo_o   = quo_neg_i ? (WORD_W'(0) - quo_ext) : quo_ext;
        rem_o   = rem_neg_i ? (WORD_W'(0) - rem_mag_i) : rem_mag_i;
    end

endmodule

// File: rtl/wsd_divider.sv
module wsd_divider
    import wsd_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [WORD_W-1:0]   dvd_hi_i,
    input  logic [WORD_W-1:0]   dvd_lo_i,
    input  logic [WORD_W-1:0]   dvsr_i,
    output logic [WORD_W-1:0]   quotient_o,
    output logic [WORD_W-1:0]   remainder_o,
    output logic                overflow_o,
    output logic                div_check_o,
    output logic                trap_o,
    output logic                done_o
);
    localparam int MAG_W = WORD_W - 1;
    localparam int CNT_W = $clog2(MAG_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MAG_W - 1);

    wsd_state_e state_q, state_d;

    // latched operands
    logic [WORD_W-1:0] op_hi_q;
    logic [MAG_W-1:0]  op_lo_q;
    logic [WORD_W-1:0] op_dvsr_q;
    logic              unused_lo_sign;

    // iteration state
    logic [WORD_W-1:0] rem_q;
    logic [MAG_W-1:0]  lo_q;
    logic [WORD_W-1:0] dvsr_q;
    logic [MAG_W-1:0]  quo_q;
    logic              dvd_neg_q;
    logic              quo_neg_q;
    logic [CNT_W-1:0]  cnt_q;

    // combinational stage outputs
    logic [WORD_W-1:0] c_hi_mag, c_dvsr_mag;
    logic [MAG_W-1:0]  c_lo_mag;
    logic              c_dvd_neg, c_quo_neg, c_check;
    logic [WORD_W-1:0] s_rem;
    logic [MAG_W-1:0]  s_lo;
    logic              s_bit;
    logic [WORD_W-1:0] f_quo, f_rem;

    assign unused_lo_sign = dvd_lo_i[WORD_W-1];

    wsd_condition #(.WORD_W(WORD_W)) u_cond (
        .hi_i       (op_hi_q),
        .lo_i       (op_lo_q),
        .dvsr_i     (op_dvsr_q),
        .hi_mag_o   (c_hi_mag),
        .lo_mag_o   (c_lo_mag),
        .dvsr_mag_o (c_dvsr_mag),
        .dvd_neg_o  (c_dvd_neg),
        .quo_neg_o  (c_quo_neg),
        .check_o    (c_check)
    );

    wsd_step #(.WORD_W(WORD_W)) u_step (
        .rem_i  (rem_q),
        .lo_i   (lo_q),
        .dvsr_i (dvsr_q),
        .rem_o  (s_rem),
        .lo_o   (s_lo),
        .bit_o  (s_bit)
    );

    wsd_fixup #(.WORD_W(WORD_W)) u_fix (
        .quo_mag_i (quo_q),
        .rem_mag_i (rem_q),
        .quo_neg_i (quo_neg_q),
        .rem_neg_i (dvd_neg_q),
        .quo_o     (f_quo),
        .rem_o     (f_rem)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i) state_d = S_PREP;
            S_PREP: state_d = c_check ? S_IDLE : S_ITER;
            S_ITER: if (cnt_q == LAST_STEP) state_d = S_FIX;
            S_FIX:  state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_hi_q   <= '0;
            op_lo_q   <= '0;
            op_dvsr_q <= '0;
            rem_q     <= '0;
            lo_q      <= '0;
            dvsr_q    <= '0;
            quo_q     <= '0;
            dvd_neg_q <= 1'b0;
            quo_neg_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        op_hi_q   <= dvd_hi_i;
                        op_lo_q   <= dvd_lo_i[MAG_W-1:0];
                        op_dvsr_q <= dvsr_i;
                    end
                end
                S_PREP: begin
                    rem_q     <= c_hi_mag;
                    lo_q      <= c_lo_mag;
                    dvsr_q    <= c_dvsr_mag;
                    dvd_neg_q <= c_dvd_neg;
                    quo_neg_q <= c_quo_neg;
                    quo_q     <= '0;
                    cnt_q     <= '0;
                end
                S_ITER: begin
                    rem_q <= s_rem;
                    lo_q  <= s_lo;
                    quo_q <= {quo_q[MAG_W-2:0], s_bit};
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                S_FIX: begin
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient_o  <= '0;
            remainder_o <= '0;
            overflow_o  <= 1'b0;
            div_check_o <= 1'b0;
            trap_o      <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == S_PREP && c_check) begin
                overflow_o  <= 1'b1;
                div_check_o <= 1'b1;
                trap_o      <= 1'b1;
                done_o      <= 1'b1;
            end
            if (state_q == S_FIX) begin
                quotient_o  <= f_quo;
                remainder_o <= f_rem;
                overflow_o  <= 1'b0;
                div_check_o <= 1'b0;
                trap_o      <= 1'b0;
                done_o      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wsd_divider_chk.sv
module wsd_divider_chk
    import wsd_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start_i,
    input logic                         done_o,
    input logic                         div_check_o,
    input logic [WORD_W-1:0]            quotient_o,
    input logic [WORD_W-1:0]            remainder_o,
    input wsd_state_e                   state_q,
    input logic [$clog2(WORD_W)-1:0]    cnt_q,
    input logic [WORD_W-1:0]            op_hi_q,
    input logic [WORD_W-1:0]            op_dvsr_q,
    input logic                         quo_neg_q
);
    localparam int MAG_W = WORD_W - 1;
    localparam int CNT_W = $clog2(WORD_W);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_check_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_check_o) |-> ($stable(quotient_o) && $stable(remainder_o)));

    assert_rem_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_check_o && remainder_o != '0)
            |-> (remainder_o[WORD_W-1] == op_hi_q[WORD_W-1]));

    assert_quo_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_check_o)
            |-> (quotient_o[WORD_W-1] == (quo_neg_q && quotient_o != '0)));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start_i) |=> ($stable(op_hi_q) && $stable(op_dvsr_q)));

    assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ITER) |-> (cnt_q < CNT_W'(MAG_W)));

endmodule

bind wsd_divider wsd_divider_chk #(.WORD_W(WORD_W)) u_wsd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .div_check_o (div_check_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .state_q     (state_q),
    .cnt_q       (cnt_q),
    .op_hi_q     (op_hi_q),
    .op_dvsr_q   (op_dvsr_q),
    .quo_neg_q   (quo_neg_q)
);

// File: tb/wsd_divider_bench.sv
module wsd_divider_bench;
    localparam int W      = 36;
    localparam int M      = W - 1;
    localparam int P      = W + M;
    localparam int LAT_OK = M + 3;
    localparam int LAT_CK = 2;

    typedef struct {
        logic        chk;
        logic [W-1:0] q;
        logic [W-1:0] r;
        int          issue;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dvd_hi_i = '0;
    logic [W-1:0] dvd_lo_i = '0;
    logic [W-1:0] dvsr_i = '0;
    logic [W-1:0] quotient_o, remainder_o;
    logic         overflow_o, div_check_o, trap_o, done_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pending = 0;
    exp_t sb[$];
    logic [W-1:0] last_q = '0;
    logic [W-1:0] last_r = '0;

    wsd_divider #(.WORD_W(W)) u_wsd_divider (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvsr_i(dvsr_i),
        .quotient_o(quotient_o), .remainder_o(remainder_o),
        .overflow_o(overflow_o), .div_check_o(div_check_o),
        .trap_o(trap_o), .done_o(done_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference: plain wide integer arithmetic
    task automatic model(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d,
                         output logic chk, output logic [W-1:0] q, output logic [W-1:0] r);
        logic [P-1:0] pair, mag, dm, qq, rr;
        logic         neg;
        pair = {h, l[M-1:0]};
        neg  = h[W-1];
        mag  = neg ? (P'(0) - pair) : pair;
        dm   = {{M{1'b0}}, (d[W-1] ? (W'(0) - d) : d)};
        chk  = (mag[P-1:M] >= dm[W-1:0]);
        q = '0;
        r = '0;
        if (!chk) begin
            qq = mag / dm;
            rr = mag % dm;
            q = (neg ^ d[W-1]) ? (W'(0) - qq[W-1:0]) : qq[W-1:0];
            r = neg ? (W'(0) - rr[W-1:0]) : rr[W-1:0];
        end
    endtask

    task automatic issue(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d);
        exp_t e;
        logic c;
        logic [W-1:0] q, r;
        model(h, l, d, c, q, r);
        if (c) begin
            q = last_q;
            r = last_r;
        end else begin
            last_q = q;
            last_r = r;
        end
        @(negedge clk);
        start_i  = 1'b1;
        dvd_hi_i = h;
        dvd_lo_i = l;
        dvsr_i   = d;
        e.chk = c; e.q = q; e.r = r; e.issue = cyc;
        sb.push_back(e);
        pending++;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_op(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d);
        issue(h, l, d);
        wait (pending == 0);
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 actual=unexpected done expected=no done");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient_o == e.q, "R2/R5 quotient", quotient_o, e.q);
                check(remainder_o == e.r, "R2/R6 remainder", remainder_o, e.r);
                check(div_check_o == e.chk && overflow_o == e.chk && trap_o == e.chk,
                      "R3/R7 flags", {33'b0, overflow_o, div_check_o, trap_o},
                      {33'b0, e.chk, e.chk, e.chk});
                check((cyc - e.issue) == (e.chk ? LAT_CK : LAT_OK), "R3/R7 latency",
                      W'(cyc - e.issue), W'(e.chk ? LAT_CK : LAT_OK));
                pending--;
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] min_w;
        min_w = {1'b1, {M{1'b0}}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(quotient_o == '0 && remainder_o == '0, "R10 results", quotient_o, '0);
        check({overflow_o, div_check_o, trap_o, done_o} == 4'b0, "R10 flags",
              {32'b0, overflow_o, div_check_o, trap_o, done_o}, '0);

        // R2 R5 R6 sign combinations
        run_op('0, W'(7), W'(2));
        run_op('1, W'(1) - W'(7) & {1'b0, {M{1'b1}}}, W'(2));
        run_op('0, W'(7), W'(0) - W'(2));
        run_op('1, (W'(0) - W'(7)) & {1'b0, {M{1'b1}}}, W'(0) - W'(2));
        // R1 low-word sign ignored: same value with bit 35 of low word set
        run_op(W'(5), W'(12345), W'(1000));
        run_op(W'(5), W'(12345) | min_w, W'(1000));
        // R4 zero divisor, and divide-check holds previous results (R3)
        run_op('0, W'(9), '0);
        // R3 most negative dividend against most negative divisor
        run_op(min_w, '0, min_w);
        run_op(min_w, '0, {1'b0, {M{1'b1}}});
        // largest quotient just inside the fit test
        run_op({1'b0, {M{1'b1}}} - W'(1), {1'b0, {M{1'b1}}}, {1'b0, {M{1'b1}}});
        run_op(W'(0) - W'(3), W'(77), min_w);
        run_op('0, '0, W'(5));
        // R8 a second start while busy is ignored
        issue(W'(3), W'(99999), W'(11));
        repeat (10) @(negedge clk);
        start_i = 1'b1; dvd_hi_i = '0; dvd_lo_i = W'(1); dvsr_i = W'(1);
        @(negedge clk);
        start_i = 1'b0;
        wait (pending == 0);
        repeat (60) @(negedge clk);
        // random operands
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] h, l, d;
            h = W'($signed({$urandom, $urandom}) >>> (1 + ($urandom % M)));
            l = W'({$urandom, $urandom});
            d = W'({$urandom, $urandom});
            if (i % 3 == 0) d = W'($signed(d) >>> ($urandom % 20));
            run_op(h, l, d);
        end
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule